// File: doc/BRIEF.md
# Chunked Transmit and Receive Data Queues

This block holds two queues of 64-bit entries, one per direction, between a register bus and a serial engine. Software does not move data one word at a time. Instead it moves a whole chunk, whose size is set by a per-direction watermark field. Every size in this block is counted in 8-byte entries.

On the transmit side, software writes 32-bit words into a staging window that lies just past the committed data. It then writes one to the transmit chunk flag, which commits the whole chunk at once. The serial engine takes the committed data as a byte stream.

On the receive side, bytes arriving from the engine are packed into entries. Software reads a chunk through a read window and releases it by writing one to the receive chunk flag.

A push that finds too little free space is ignored and raises a sticky overflow flag. A pop that finds too little data is ignored and raises a sticky underflow flag. Each direction has a clear control that flushes that queue. Its clear bit reads one for a single cycle and then returns to zero by itself. The queue depth must be a power of two.

Top module: `cfifo_chunk_top`

## Requirements
- R1: The watermark field f (reset value 0) sets the chunk to 8*(f+1) bytes, which is f+1 entries or 2*(f+1) window words. A field write takes effect on the following cycle; a push or pop in the cycle of the write still uses the old field.
- R2: A transmit window write to word w stores data into staged entry w/2, counted past the committed data: even w fills bits 31:0 and odd w fills bits 63:32. A write whose entry index is not below the current free space is ignored and does not change the stream.
- R3: A transmit push with free space of at least one chunk commits the staged entries 0..f in order. It raises tx_fill by f+1.
- R4: A transmit push with free space below one chunk is ignored: tx_fill does not grow. It sets tx_ovf, which stays set until the transmit clear.
- R5: tx_wm_flag equals (DEPTH - tx_fill >= f+1) for the current transmit field. It is valid in the cycle after any change.
- R6: The engine byte stream sends committed entries oldest first, each from bits 7:0 up to bits 63:56. tx_fill drops by one when the eighth byte of an entry is accepted (eng_tx_valid and eng_tx_ready both high).
- R7: Received bytes fill an entry from bits 7:0 upward, and the entry counts in rx_fill only after its eighth byte. eng_rx_ready is low exactly when rx_fill equals DEPTH, and no byte is taken while it is low.
- R8: A receive window read of word w returns half w%2 of the entry w/2 places after the oldest. The data appears on rxw_rdata in the cycle after rxw_re.
- R9: A receive pop with rx_fill of at least f+1 removes the f+1 oldest entries. rx_wm_flag equals (rx_fill >= f+1).
- R10: A receive pop with rx_fill below f+1 is ignored: rx_fill does not shrink. It sets rx_udf, which stays set until the receive clear.
- R11: A clear write empties its queue and drops any partly sent or partly received entry. It clears that direction's sticky flag and sets that direction's clear bit for exactly one cycle.
- R12: Both fill levels count whole 8-byte entries and never exceed DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wm_wr | input | 1 | Write wm_wdata into the transmit watermark field |
| rx_wm_wr | input | 1 | Write wm_wdata into the receive watermark field |
| wm_wdata | input | log2(DEPTH) | Watermark field value (chunk entries minus one) |
| tx_clr_wr | input | 1 | Write one to the transmit clear bit |
| rx_clr_wr | input | 1 | Write one to the receive clear bit |
| txw_we | input | 1 | Transmit window word write |
| txw_addr | input | log2(DEPTH)+1 | Transmit window word index |
| txw_wdata | input | 32 | Transmit window word data |
| tx_push | input | 1 | Write one to the transmit chunk flag (push a chunk) |
| rxw_re | input | 1 | Receive window word read |
| rxw_addr | input | log2(DEPTH)+1 | Receive window word index |
| rxw_rdata | output | 32 | Receive window word data, one cycle after rxw_re |
| rx_pop | input | 1 | Write one to the receive chunk flag (pop a chunk) |
| tx_wm_flag | output | 1 | Free space holds at least one chunk |
| rx_wm_flag | output | 1 | Stored data holds at least one chunk |
| tx_ovf | output | 1 | Sticky: a push was refused |
| rx_udf | output | 1 | Sticky: a pop was refused |
| tx_fill | output | log2(DEPTH)+1 | Committed transmit entries not yet fully sent |
| rx_fill | output | log2(DEPTH)+1 | Complete receive entries held |
| tx_clr_bit | output | 1 | Transmit clear bit, self-clearing |
| rx_clr_bit | output | 1 | Receive clear bit, self-clearing |
| eng_tx_valid | output | 1 | Transmit byte available to the engine |
| eng_tx_ready | input | 1 | Engine accepts the transmit byte |
| eng_tx_byte | output | 8 | Transmit byte |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | Block can accept a received byte |
| eng_rx_byte | input | 8 | Received byte |

## Verification
The bench builds the block with DEPTH set to 8, so the three-bit watermark field covers every chunk size from one entry to the whole queue. Filling either queue completely and wrapping its pointers takes only a few dozen cycles. This brings two boundaries within reach in every run: a chunk of the full depth, and a refused push or pop against a full or empty queue. Random watermark changes between chunks place chunks at every alignment of the pointers. Partial receive entries are interrupted by a clear.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int ENTRY_W = 2 * WORD_W;
  localparam int BYTES_PER_ENTRY = ENTRY_W / BYTE_W;
  localparam int BCNT_W  = $clog2(BYTES_PER_ENTRY);

  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [ENTRY_W-1:0] entry_t;
endpackage

// File: rtl/cfifo_wm_reg.sv
module cfifo_wm_reg #(
  parameter int WM_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wm_wr,
  input  logic [WM_W-1:0] wm_wdata,
  input  logic            clr_wr,
  output logic [WM_W-1:0] wm_q,
  output logic [WM_W-1:0] wm_next,
  output logic            clr_bit
);
  always_comb wm_next = wm_wr ? wm_wdata : wm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wm_q    <= '0;
      clr_bit <= 1'b0;
    end else begin
      wm_q    <= wm_next;
      clr_bit <= clr_wr;
    end
  end
endmodule

// File: rtl/cfifo_tx_path.sv
module cfifo_tx_path
  import cfifo_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int WA = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [AW-1:0] wm_q,
  input  logic [AW-1:0] wm_next,
  input  logic          win_we,
  input  logic [WA-1:0] win_addr,
  input  word_t         win_wdata,
  input  logic          push,
  input  logic          eng_ready,
  output logic [CW-1:0] fill,
  output logic          wm_flag,
  output logic          ovf,
  output logic          eng_valid,
  output byte_t         eng_byte
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  word_t mem_lo [DEPTH];
  word_t mem_hi [DEPTH];
  word_t rd_lo, rd_hi;

  logic [AW-1:0] wr_ptr, rd_ptr, win_idx, win_slot;
  logic [CW-1:0] count, count_nxt, free, chunk, chunk_nxt;
  logic win_ok, push_ok, issue, pend, have, last;
  logic [BCNT_W-1:0] bcnt;
  entry_t shreg;

  always_comb begin
    free      = FULL - count;
    chunk     = {1'b0, wm_q} + CW'(1);
    chunk_nxt = {1'b0, wm_next} + CW'(1);
    win_idx   = win_addr[WA-1:1];
    win_slot  = wr_ptr + win_idx;
    win_ok    = win_we && ({1'b0, win_idx} < free);
    push_ok   = push && !flush && (chunk <= free);
    issue     = !have && !pend && (count != '0);
    last      = have && eng_ready && (bcnt == BCNT_W'(BYTES_PER_ENTRY - 1));
    count_nxt = count;
    if (push_ok) count_nxt = count_nxt + chunk;
    if (last)    count_nxt = count_nxt - CW'(1);
    if (flush)   count_nxt = '0;
  end

  // Lower and upper halves kept in separate simple dual-port memories.
  always_ff @(posedge clk) begin
    if (win_ok && !win_addr[0]) mem_lo[win_slot] <= win_wdata;
    rd_lo <= mem_lo[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (win_ok && win_addr[0]) mem_hi[win_slot] <= win_wdata;
    rd_hi <= mem_hi[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      pend   <= 1'b0;
      have   <= 1'b0;
      bcnt   <= '0;
      shreg  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + wm_q + AW'(1);
      if (push && !push_ok) ovf <= 1'b1;
      if (issue) begin
        rd_ptr <= rd_ptr + AW'(1);
        pend   <= 1'b1;
      end
      if (pend) begin
        shreg <= {rd_hi, rd_lo};
        have  <= 1'b1;
        bcnt  <= '0;
        pend  <= 1'b0;
      end else if (have && eng_ready) begin
        shreg <= {byte_t'(0), shreg[ENTRY_W-1:BYTE_W]};
        bcnt  <= bcnt + BCNT_W'(1);
        if (last) have <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      wm_flag <= 1'b1;
    end else begin
      count   <= count_nxt;
      wm_flag <= (FULL - count_nxt) >= chunk_nxt;
    end
  end

  assign fill      = count;
  assign eng_valid = have;
  assign eng_byte  = shreg[BYTE_W-1:0];
endmodule

// File: rtl/cfifo_rx_path.sv
module cfifo_rx_path
  import cfifo_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int WA = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [AW-1:0] wm_q,
  input  logic [AW-1:0] wm_next,
  input  logic          win_re,
  input  logic [WA-1:0] win_addr,
  output word_t         win_rdata,
  input  logic          pop,
  input  logic          eng_valid,
  input  byte_t         eng_byte,
  output logic          eng_ready,
  output logic [CW-1:0] fill,
  output logic          wm_flag,
  output logic          udf
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  word_t mem_lo [DEPTH];
  word_t mem_hi [DEPTH];
  word_t q_lo, q_hi;
  logic  q_sel;

  logic [AW-1:0] wr_ptr, rd_ptr, rd_slot;
  logic [CW-1:0] count, count_nxt, chunk, chunk_nxt;
  logic take, done, pop_ok;
  logic [BCNT_W-1:0] bcnt;
  entry_t asm_q, entry;

  always_comb begin
    chunk     = {1'b0, wm_q} + CW'(1);
    chunk_nxt = {1'b0, wm_next} + CW'(1);
    take      = eng_valid && eng_ready && !flush;
    done      = take && (bcnt == BCNT_W'(BYTES_PER_ENTRY - 1));
    entry     = {eng_byte, asm_q[ENTRY_W-1:BYTE_W]};
    pop_ok    = pop && !flush && (chunk <= count);
    rd_slot   = rd_ptr + win_addr[WA-1:1];
    count_nxt = count;
    if (done)   count_nxt = count_nxt + CW'(1);
    if (pop_ok) count_nxt = count_nxt - chunk;
    if (flush)  count_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (done) mem_lo[wr_ptr] <= entry[WORD_W-1:0];
    if (win_re) q_lo <= mem_lo[rd_slot];
  end

  always_ff @(posedge clk) begin
    if (done) mem_hi[wr_ptr] <= entry[ENTRY_W-1:WORD_W];
    if (win_re) q_hi <= mem_hi[rd_slot];
  end

  always_ff @(posedge clk) begin
    if (rst) q_sel <= 1'b0;
    else if (win_re) q_sel <= win_addr[0];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      bcnt   <= '0;
      asm_q  <= '0;
      udf    <= 1'b0;
    end else begin
      if (take) begin
        asm_q <= entry;
        bcnt  <= bcnt + BCNT_W'(1);
      end
      if (done) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok) rd_ptr <= rd_ptr + wm_q + AW'(1);
      if (pop && !pop_ok) udf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      wm_flag   <= 1'b0;
      eng_ready <= 1'b1;
    end else begin
      count     <= count_nxt;
      wm_flag   <= count_nxt >= chunk_nxt;
      eng_ready <= count_nxt != FULL;
    end
  end

  assign fill      = count;
  assign win_rdata = q_sel ? q_hi : q_lo;
endmodule

// File: rtl/cfifo_chunk_top.sv
module cfifo_chunk_top
  import cfifo_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int WA = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_wm_wr,
  input  logic          rx_wm_wr,
  input  logic [AW-1:0] wm_wdata,
  input  logic          tx_clr_wr,
  input  logic          rx_clr_wr,
  input  logic          txw_we,
  input  logic [WA-1:0] txw_addr,
  input  logic [31:0]   txw_wdata,
  input  logic          tx_push,
  input  logic          rxw_re,
  input  logic [WA-1:0] rxw_addr,
  output logic [31:0]   rxw_rdata,
  input  logic          rx_pop,
  output logic          tx_wm_flag,
  output logic          rx_wm_flag,
  output logic          tx_ovf,
  output logic          rx_udf,
  output logic [CW-1:0] tx_fill,
  output logic [CW-1:0] rx_fill,
  output logic          tx_clr_bit,
  output logic          rx_clr_bit,
  output logic          eng_tx_valid,
  input  logic          eng_tx_ready,
  output logic [7:0]    eng_tx_byte,
  input  logic          eng_rx_valid,
  output logic          eng_rx_ready,
  input  logic [7:0]    eng_rx_byte
);
  logic [AW-1:0] tx_wm_q, tx_wm_nxt, rx_wm_q, rx_wm_nxt;

  cfifo_wm_reg #(.WM_W(AW)) u_tx_wm (
    .clk(clk), .rst(rst), .wm_wr(tx_wm_wr), .wm_wdata(wm_wdata),
    .clr_wr(tx_clr_wr), .wm_q(tx_wm_q), .wm_next(tx_wm_nxt),
    .clr_bit(tx_clr_bit)
  );

  cfifo_wm_reg #(.WM_W(AW)) u_rx_wm (
    .clk(clk), .rst(rst), .wm_wr(rx_wm_wr), .wm_wdata(wm_wdata),
    .clr_wr(rx_clr_wr), .wm_q(rx_wm_q), .wm_next(rx_wm_nxt),
    .clr_bit(rx_clr_bit)
  );

  cfifo_tx_path #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst(rst), .flush(tx_clr_wr),
    .wm_q(tx_wm_q), .wm_next(tx_wm_nxt),
    .win_we(txw_we), .win_addr(txw_addr), .win_wdata(txw_wdata),
    .push(tx_push), .eng_ready(eng_tx_ready),
    .fill(tx_fill), .wm_flag(tx_wm_flag), .ovf(tx_ovf),
    .eng_valid(eng_tx_valid), .eng_byte(eng_tx_byte)
  );

  cfifo_rx_path #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst(rst), .flush(rx_clr_wr),
    .wm_q(rx_wm_q), .wm_next(rx_wm_nxt),
    .win_re(rxw_re), .win_addr(rxw_addr), .win_rdata(rxw_rdata),
    .pop(rx_pop), .eng_valid(eng_rx_valid), .eng_byte(eng_rx_byte),
    .eng_ready(eng_rx_ready), .fill(rx_fill), .wm_flag(rx_wm_flag),
    .udf(rx_udf)
  );
endmodule

// File: rtl/cfifo_chunk_chk.sv
module cfifo_chunk_chk #(
  parameter  int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_push,
  input logic          tx_clr_wr,
  input logic          rx_pop,
  input logic          rx_clr_wr,
  input logic [CW-1:0] tx_fill,
  input logic [CW-1:0] rx_fill,
  input logic [AW-1:0] tx_wm_q,
  input logic [AW-1:0] rx_wm_q,
  input logic          tx_wm_flag,
  input logic          rx_wm_flag,
  input logic          tx_ovf,
  input logic          rx_udf,
  input logic          tx_clr_bit,
  input logic          eng_tx_valid,
  input logic          eng_tx_ready,
  input logic          eng_rx_ready
);
  // R5
  a_r5_tx_flag: assert property (@(posedge clk) disable iff (rst)
    tx_wm_flag == ((DEPTH - int'(tx_fill)) >= (int'(tx_wm_q) + 1)));

  // R9
  a_r9_rx_flag: assert property (@(posedge clk) disable iff (rst)
    rx_wm_flag == (int'(rx_fill) >= (int'(rx_wm_q) + 1)));

  // R3
  a_r3_push_commit: assert property (@(posedge clk) disable iff (rst)
    (tx_push && !tx_clr_wr && !(eng_tx_valid && eng_tx_ready) &&
     ((DEPTH - int'(tx_fill)) >= (int'(tx_wm_q) + 1)))
    |=> (int'(tx_fill) == int'($past(tx_fill)) + int'($past(tx_wm_q)) + 1));

  // R4
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (tx_push && !tx_clr_wr && ((DEPTH - int'(tx_fill)) < (int'(tx_wm_q) + 1)))
    |=> (tx_ovf && (tx_fill <= $past(tx_fill))));

  // R10
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && !rx_clr_wr && (int'(rx_fill) < (int'(rx_wm_q) + 1)))
    |=> (rx_udf && (rx_fill >= $past(rx_fill))));

  // R11
  a_r11_tx_flush: assert property (@(posedge clk) disable iff (rst)
    tx_clr_wr |=> (tx_fill == '0) && tx_clr_bit && !tx_ovf && !eng_tx_valid);

  // R7
  a_r7_rx_ready: assert property (@(posedge clk) disable iff (rst)
    eng_rx_ready == (int'(rx_fill) != DEPTH));

  // R12
  a_r12_fill_bound: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_fill) <= DEPTH) && (int'(rx_fill) <= DEPTH));
endmodule

bind cfifo_chunk_top cfifo_chunk_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/cfifo_chunk_top_test.sv
module cfifo_chunk_top_test;
  localparam int DEPTH = 8;
  localparam int AW = 3;
  localparam int CW = 4;
  localparam int WA = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, tx_wm_wr, rx_wm_wr, tx_clr_wr, rx_clr_wr, txw_we, tx_push;
  logic rxw_re, rx_pop, eng_tx_ready, eng_rx_valid;
  logic [AW-1:0] wm_wdata;
  logic [WA-1:0] txw_addr, rxw_addr;
  logic [31:0] txw_wdata, rxw_rdata;
  logic [7:0] eng_rx_byte, eng_tx_byte;
  logic tx_wm_flag, rx_wm_flag, tx_ovf, rx_udf, tx_clr_bit, rx_clr_bit;
  logic eng_tx_valid, eng_rx_ready;
  logic [CW-1:0] tx_fill, rx_fill;

  cfifo_chunk_top #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .tx_wm_wr(tx_wm_wr), .rx_wm_wr(rx_wm_wr),
    .wm_wdata(wm_wdata), .tx_clr_wr(tx_clr_wr), .rx_clr_wr(rx_clr_wr),
    .txw_we(txw_we), .txw_addr(txw_addr), .txw_wdata(txw_wdata),
    .tx_push(tx_push), .rxw_re(rxw_re), .rxw_addr(rxw_addr),
    .rxw_rdata(rxw_rdata), .rx_pop(rx_pop), .tx_wm_flag(tx_wm_flag),
    .rx_wm_flag(rx_wm_flag), .tx_ovf(tx_ovf), .rx_udf(rx_udf),
    .tx_fill(tx_fill), .rx_fill(rx_fill), .tx_clr_bit(tx_clr_bit),
    .rx_clr_bit(rx_clr_bit), .eng_tx_valid(eng_tx_valid),
    .eng_tx_ready(eng_tx_ready), .eng_tx_byte(eng_tx_byte),
    .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready),
    .eng_rx_byte(eng_rx_byte)
  );

  int nchk = 0, nbad = 0;
  logic [7:0]  tx_exp[$];
  logic [63:0] rx_q[$];
  logic [7:0]  rx_part[$];
  int tx_fill_m = 0, tx_cons = 0, tx_wm_m = 0, rx_wm_m = 0;
  bit tx_ovf_m = 0, rx_udf_m = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_entry();
    logic [63:0] e = '0;
    for (int b = 0; b < 8; b++) e[8*b +: 8] = rx_part[b];
    return e;
  endfunction

  task automatic step();
    if (eng_tx_valid && eng_tx_ready) begin
      if (tx_exp.size() == 0) chk("R6 byte with empty model", 1, 0);
      else chk("R6 byte order", {56'd0, eng_tx_byte}, {56'd0, tx_exp.pop_front()});
      tx_cons++;
      if (tx_cons == 8) begin tx_cons = 0; tx_fill_m--; end
    end
    if (eng_rx_valid && eng_rx_ready) begin
      rx_part.push_back(eng_rx_byte);
      if (rx_part.size() == 8) begin
        rx_q.push_back(pack_entry());
        rx_part.delete();
      end
    end
    @(negedge clk);
  endtask

  task automatic check_state();
    chk("R12 tx_fill", {60'd0, tx_fill}, 64'(tx_fill_m));
    chk("R12 rx_fill", {60'd0, rx_fill}, 64'(rx_q.size()));
    chk("R5 tx_wm_flag", {63'd0, tx_wm_flag}, {63'd0, (DEPTH - tx_fill_m) >= tx_wm_m + 1});
    chk("R9 rx_wm_flag", {63'd0, rx_wm_flag}, {63'd0, rx_q.size() >= rx_wm_m + 1});
    chk("R4 tx_ovf", {63'd0, tx_ovf}, {63'd0, tx_ovf_m});
    chk("R10 rx_udf", {63'd0, rx_udf}, {63'd0, rx_udf_m});
    chk("R7 eng_rx_ready", {63'd0, eng_rx_ready}, {63'd0, rx_q.size() != DEPTH});
  endtask

  task automatic set_wm(input bit is_rx, input int v);
    wm_wdata = AW'(v);
    if (is_rx) rx_wm_wr = 1; else tx_wm_wr = 1;
    step();
    tx_wm_wr = 0; rx_wm_wr = 0;
    if (is_rx) rx_wm_m = v; else tx_wm_m = v;
  endtask

  task automatic tx_write(input int w, input logic [31:0] d);
    txw_we = 1; txw_addr = WA'(w); txw_wdata = d;
    step();
    txw_we = 0;
  endtask

  task automatic tx_push_op();
    bit ok = (DEPTH - tx_fill_m) >= tx_wm_m + 1;
    tx_push = 1; step(); tx_push = 0;
    if (!ok) tx_ovf_m = 1;
  endtask

  // R1 R2 R3: stage a full chunk through the window, then commit it.
  task automatic tx_load_push();
    int n = tx_wm_m + 1;
    logic [63:0] ent[DEPTH];
    for (int e = 0; e < n; e++) begin
      ent[e] = {$urandom, $urandom};
      tx_write(2*e, ent[e][31:0]);
      tx_write(2*e + 1, ent[e][63:32]);
    end
    tx_push_op();
    for (int e = 0; e < n; e++)
      for (int b = 0; b < 8; b++) tx_exp.push_back(ent[e][8*b +: 8]);
    tx_fill_m += n;
  endtask

  task automatic drain(input int k, input bit always_rdy);
    for (int i = 0; i < k; i++) begin
      eng_tx_ready = always_rdy ? 1'b1 : 1'($urandom_range(0, 1));
      step();
    end
    eng_tx_ready = 0;
  endtask

  task automatic feed(input int k, input bit always_vld);
    for (int i = 0; i < k; i++) begin
      eng_rx_valid = always_vld ? 1'b1 : 1'($urandom_range(0, 1));
      eng_rx_byte = 8'($urandom);
      step();
    end
    eng_rx_valid = 0;
  endtask

  // R8 R9: read every word of the oldest chunk, then release it.
  task automatic rx_read_pop();
    int n = rx_wm_m + 1;
    logic [63:0] e;
    if (rx_q.size() >= n) begin
      for (int w = 0; w < 2*n; w++) begin
        rxw_re = 1; rxw_addr = WA'(w);
        step();
        rxw_re = 0;
        e = rx_q[w/2];
        chk("R8 rx window word", {32'd0, rxw_rdata}, {32'd0, e[32*(w%2) +: 32]});
      end
      rx_pop = 1; step(); rx_pop = 0;
      for (int i = 0; i < n; i++) void'(rx_q.pop_front());
    end else begin
      rx_pop = 1; step(); rx_pop = 0;
      rx_udf_m = 1;
    end
  endtask

  task automatic clear(input bit is_rx);
    if (is_rx) rx_clr_wr = 1; else tx_clr_wr = 1;
    step();
    rx_clr_wr = 0; tx_clr_wr = 0;
    if (is_rx) begin
      rx_q.delete(); rx_part.delete(); rx_udf_m = 0;
      chk("R11 rx clear bit set", {63'd0, rx_clr_bit}, 64'd1);
    end else begin
      tx_exp.delete(); tx_fill_m = 0; tx_cons = 0; tx_ovf_m = 0;
      chk("R11 tx clear bit set", {63'd0, tx_clr_bit}, 64'd1);
      chk("R11 tx no byte after clear", {63'd0, eng_tx_valid}, 64'd0);
    end
    check_state();
    step();
    chk("R11 clear bit self-clears", {62'd0, tx_clr_bit, rx_clr_bit}, 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1; tx_wm_wr = 0; rx_wm_wr = 0; wm_wdata = '0; tx_clr_wr = 0;
    rx_clr_wr = 0; txw_we = 0; txw_addr = '0; txw_wdata = '0; tx_push = 0;
    rxw_re = 0; rxw_addr = '0; rx_pop = 0; eng_tx_ready = 0;
    eng_rx_valid = 0; eng_rx_byte = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_state();
    chk("R11 clear bits at reset", {62'd0, tx_clr_bit, rx_clr_bit}, 64'd0);
    chk("R6 no byte at reset", {63'd0, eng_tx_valid}, 64'd0);

    // R7 R1: seven bytes do not make an entry; the eighth makes a default-size chunk
    feed(7, 1); check_state();
    feed(1, 1);
    chk("R1 default chunk flag", {63'd0, rx_wm_flag}, 64'd1);
    check_state();
    rx_read_pop(); check_state();

    // R7: fill the receive queue completely, then offer more bytes
    set_wm(1, DEPTH - 1);
    feed(8*DEPTH + 5, 1);
    chk("R7 full stops intake", {60'd0, rx_fill}, 64'(DEPTH));
    check_state();
    rx_read_pop(); check_state();
    rx_read_pop();
    chk("R10 underflow sticky", {63'd0, rx_udf}, 64'd1);
    check_state();
    clear(1);

    // R11: a partial entry is dropped by clear
    feed(3, 1); clear(1);
    set_wm(1, 0); feed(8, 1); check_state(); rx_read_pop(); check_state();

    // R2 R3 R4: full transmit queue, window write ignored, refused push
    set_wm(0, DEPTH - 1);
    tx_load_push(); check_state();
    tx_write(0, 32'hDEAD_BEEF);
    tx_push_op();
    chk("R4 refused push keeps fill", {60'd0, tx_fill}, 64'(DEPTH));
    check_state();
    drain(8*DEPTH + 40, 1);
    chk("R2 all expected bytes sent", 64'(tx_exp.size()), 64'd0);
    check_state();
    clear(0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      case ($urandom_range(0, 7))
        0: set_wm(0, $urandom_range(0, DEPTH - 1));
        1, 2: if ((DEPTH - tx_fill_m) >= tx_wm_m + 1) tx_load_push(); else tx_push_op();
        3: drain($urandom_range(1, 24), 0);
        4: set_wm(1, $urandom_range(0, DEPTH - 1));
        5: feed($urandom_range(1, 24), 0);
        6: rx_read_pop();
        default: clear(1'($urandom_range(0, 1)));
      endcase
      check_state();
    end

    drain(8*DEPTH + 40, 1);
    chk("R6 final drain", 64'(tx_exp.size()), 64'd0);
    check_state();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule